// File: doc/BRIEF.md
# Clocked Serial Byte Port

This block moves one byte at a time over a three-wire synchronous serial link: a serial clock, a transmit line and a receive line. A processor bus sees two byte-wide locations, a data location and a control location. Software fills the data location, then sets either the transmit or the receive enable. The block runs eight serial clock periods, shifting the byte out or collecting a byte in. When the byte is complete it drops the enable, raises an end flag and, if allowed, an interrupt.

The serial clock either comes from a programmable divider on the system clock or from an external source on the same pin. A 3-bit speed code picks one of seven divide ratios or, with its all-ones value, the external source. While an enable is set, writes to the enable bits are ignored. Writes to the speed code and to the interrupt enable always take effect. A stop-I/O input aborts any transfer.

Top module: `csio_ctrl`

## Requirements
- R1: After reset the control location (address 1) reads 8'h07. Its layout is end flag bit 7 (read-only), interrupt enable bit 6, receive enable bit 5, transmit enable bit 4, bit 3 reads 0, speed code bits 2:0. The clock pin is not driven, the transmit line is 1 and the interrupt is low. Address 0 is the data location.
- R2: Speed codes 0 to 6 give a serial clock period of 20 << code system clocks on the clock output.
- R3: Transmit data leaves least-significant bit first. Each bit changes after a falling serial clock edge and is valid at the next rising edge.
- R4: On the eighth rising serial edge the active enable clears by itself and the end flag sets.
- R5: The interrupt output is high exactly while both the end flag and the interrupt enable are 1.
- R6: Receive data is sampled on rising serial edges, least-significant bit first. After the eighth rising edge the data location holds the received byte.
- R7: A bus read of the data location, or a control write that sets an enable, clears the end flag.
- R8: Speed code 7 leaves the clock pin undriven. Data then shifts on the edges of the external clock, after a two-flop synchroniser.
- R9: A control write with both enables set starts a transmit only; receive enable stays 0.
- R10: Asserting stop-I/O clears both enables without setting the end flag.
- R11: The serial clock output stays 1 whenever no enable is set.
- R12: When the end of a byte and a data-location read fall in the same cycle, the end flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (side effect on data location) |
| bus_addr | input | 1 | 0 = data, 1 = control |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational on bus_addr |
| stop_io | input | 1 | Stop-I/O mode, aborts transfers |
| sclk_i | input | 1 | External serial clock input |
| sclk_o | output | 1 | Internal serial clock output |
| sclk_oe | output | 1 | Clock pin drive enable |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | End-of-byte interrupt |

## Verification
Two events can meet in one cycle: the hardware setting the end flag on the final rising edge, and a software read of the data location that clears it. The bench provokes this in external clock mode. It controls the clock pin itself, so the cycle of the final edge is known: two synchroniser stages plus the edge detector put it three system clocks after the pin rises. The bench places the data read exactly in that cycle and expects the flag and interrupt to remain set. A read one cycle later must then clear the flag.

// File: rtl/csio_pkg.sv
// Package: shared constants for the clocked serial byte port.
// Assumes an 8-bit bus with a 1-bit address.
package csio_pkg;
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;
    localparam int   BIT_EF    = 7;
    localparam int   BIT_EIE   = 6;
    localparam int   BIT_RE    = 5;
    localparam int   BIT_TE    = 4;
endpackage

// File: rtl/csio_clkgen.sv
// Serial clock source: programmable divider or synchronised external clock.
// Produces one-cycle rise/fall strobes in the system clock domain.
// Assumes an external clock slower than the fastest internal ratio.
module csio_clkgen #(
    parameter int HALF_BASE = 10,
    parameter int SS_W      = 3,
    parameter int CNT_W     = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic [SS_W-1:0] ss,
    input  logic            sclk_in,
    output logic            rise_stb,
    output logic            fall_stb,
    output logic            sclk_out,
    output logic            sclk_oe
);
    logic             ext_mode;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt_q;
    logic             lvl_q;
    logic             sync1_q, sync2_q, sync3_q;
    logic             tick;

    assign ext_mode = &ss;
    assign half_m1  = (CNT_W'(HALF_BASE) << ss) - CNT_W'(1);

    // Two-flop synchroniser plus history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            sync3_q <= 1'b1;
        end else begin
            sync1_q <= sclk_in;
            sync2_q <= sync1_q;
            sync3_q <= sync2_q;
        end
    end

    // Half-period divider; idles high when inactive or external
    always_ff @(posedge clk) begin
        if (!rst_n || !active || ext_mode) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (cnt_q == half_m1) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick     = active && !ext_mode && (cnt_q == half_m1);
    assign fall_stb = ext_mode ? (active && sync3_q && !sync2_q) : (tick && lvl_q);
    assign rise_stb = ext_mode ? (active && !sync3_q && sync2_q) : (tick && !lvl_q);
    assign sclk_out = lvl_q | ~active;
    assign sclk_oe  = ~ext_mode;

    AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n) !(rise_stb && fall_stb)); // R2
endmodule

// File: rtl/csio_shifter.sv
// Shift engine: counts rising edges, drives transmit bits on falling edges,
// samples receive bits on rising edges, LSB first. Assumes one-cycle strobes.
module csio_shifter #(
    parameter int DATA_W = 8,
    parameter int BCNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tx_mode,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              rxd,
    output logic              txd,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    logic [BCNT_W-1:0] bitcnt_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              txd_q;

    // Bit counter advances on each rising serial edge of a transfer
    always_ff @(posedge clk) begin
        if (!rst_n || !active) bitcnt_q <= '0;
        else if (rise_stb)     bitcnt_q <= bitcnt_q + BCNT_W'(1);
    end

    // Transmit holding copy captured at start
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_sh_q <= '0;
        else if (load) tx_sh_q <= load_data;
    end

    // Transmit line update on falling serial edge
    always_ff @(posedge clk) begin
        if (!rst_n)                            txd_q <= 1'b1;
        else if (active && tx_mode && fall_stb) txd_q <= tx_sh_q[bitcnt_q];
    end

    // Receive shift on rising serial edge, LSB arrives first
    always_ff @(posedge clk) begin
        if (!rst_n)                              rx_sh_q <= '0;
        else if (active && !tx_mode && rise_stb) rx_sh_q <= {rxd, rx_sh_q[DATA_W-1:1]};
    end

    assign txd     = txd_q;
    assign done    = active && rise_stb && (bitcnt_q == BCNT_W'(DATA_W - 1));
    assign rx_data = {rxd, rx_sh_q[DATA_W-1:1]};

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n) done |=> (bitcnt_q == '0)); // R4
endmodule

// File: rtl/csio_ctrl.sv
// Top: bus registers, enable/flag control and interrupt of the clocked serial
// byte port. Assumes single-cycle bus strobes and a synchronous reset.
module csio_ctrl
    import csio_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SS_W     = 3,
    parameter int BASE_DIV = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_io,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              txd,
    input  logic              rxd,
    output logic              irq
);
    localparam int HALF_BASE = BASE_DIV / 2;
    localparam int CNT_W     = $clog2(HALF_BASE << ((1 << SS_W) - 2)) + 1;
    localparam int BCNT_W    = $clog2(DATA_W);

    logic [DATA_W-1:0] data_q;
    logic              te_q, re_q, eie_q, ef_q;
    logic [SS_W-1:0]   ss_q;
    logic              active, start, tx_load, done;
    logic              wr_ctrl, wr_data, rd_data;
    logic              rise_stb, fall_stb;
    logic [DATA_W-1:0] rx_data;
    logic              wdata_unused;

    assign active  = te_q | re_q;
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign rd_data = bus_rd && (bus_addr == ADDR_DATA);
    assign start   = wr_ctrl && !active && !stop_io &&
                     (bus_wdata[BIT_TE] || bus_wdata[BIT_RE]);
    assign tx_load = start && bus_wdata[BIT_TE];
    assign wdata_unused = ^{bus_wdata[DATA_W-1:BIT_EF], bus_wdata[3]};

    // Enable bits: set by write when idle, cleared by stop or end of byte
    always_ff @(posedge clk) begin
        if (!rst_n || stop_io || done) begin
            te_q <= 1'b0;
            re_q <= 1'b0;
        end else if (start) begin
            te_q <= bus_wdata[BIT_TE];
            re_q <= bus_wdata[BIT_RE] && !bus_wdata[BIT_TE];
        end
    end

    // Interrupt enable and speed code, always writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eie_q <= 1'b0;
            ss_q  <= '1;
        end else if (wr_ctrl) begin
            eie_q <= bus_wdata[BIT_EIE];
            ss_q  <= bus_wdata[SS_W-1:0];
        end
    end

    // End flag: set at end of byte wins over software clears
    always_ff @(posedge clk) begin
        if (!rst_n)                ef_q <= 1'b0;
        else if (done)             ef_q <= 1'b1;
        else if (rd_data || start) ef_q <= 1'b0;
    end

    // Data location: received byte at end of receive, else bus write
    always_ff @(posedge clk) begin
        if (!rst_n)             data_q <= '0;
        else if (done && re_q)  data_q <= rx_data;
        else if (wr_data)       data_q <= bus_wdata;
    end

    // Read mux
    always_comb begin
        bus_rdata = data_q;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata                = '0;
            bus_rdata[BIT_EF]        = ef_q;
            bus_rdata[BIT_EIE]       = eie_q;
            bus_rdata[BIT_RE]        = re_q;
            bus_rdata[BIT_TE]        = te_q;
            bus_rdata[SS_W-1:0]      = ss_q;
        end
    end

    assign irq = ef_q & eie_q;

    csio_clkgen #(.HALF_BASE(HALF_BASE), .SS_W(SS_W), .CNT_W(CNT_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .active(active), .ss(ss_q), .sclk_in(sclk_i),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .sclk_out(sclk_o), .sclk_oe(sclk_oe)
    );

    csio_shifter #(.DATA_W(DATA_W), .BCNT_W(BCNT_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .active(active), .tx_mode(te_q), .load(tx_load),
        .load_data(data_q), .rise_stb(rise_stb), .fall_stb(fall_stb), .rxd(rxd),
        .txd(txd), .done(done), .rx_data(rx_data)
    );

    AST_EN_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(te_q && re_q)); // R9
    AST_EF_AT_END:  assert property (@(posedge clk) disable iff (!rst_n) $rose(ef_q) |-> $past(active)); // R4
    AST_DONE_CLR:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !active); // R4
    AST_STOP_CLR:   assert property (@(posedge clk) disable iff (!rst_n) stop_io |=> !active); // R10
    AST_IDLE_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) !active |-> sclk_o); // R11
endmodule

// File: tb/test_csio_ctrl.sv
module test_csio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stop_io = 1'b0, sclk_i = 1'b1, rxd = 1'b1;
    logic       sclk_o, sclk_oe, txd, irq;

    int errors = 0, checks = 0, finished = 0;

    always #2.5 clk = ~clk;

    csio_ctrl i_csio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_io(stop_io), .sclk_i(sclk_i),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .txd(txd), .rxd(rxd), .irq(irq)
    );

    wire sclk_line = sclk_oe ? sclk_o : sclk_i;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Period measurement of the internal clock output
    int cyc = 0, last_rise = 0, period = 0;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge sclk_o) begin
        period    = cyc - last_rise;
        last_rise = cyc;
    end

    // Scoreboard: transmit monitor pops expected bytes
    logic [7:0] exp_tx[$];
    logic       mon_en = 1'b0;
    int         mon_cnt = 0;
    logic [7:0] mon_byte = '0;
    always @(posedge sclk_line) begin
        if (mon_en) begin
            mon_byte[mon_cnt] = txd;
            mon_cnt++;
            if (mon_cnt == 8) begin
                mon_cnt = 0;
                if (exp_tx.size() == 0) check("R3 unexpected byte", {24'd0, mon_byte}, 32'hFFFF);
                else check("R3 tx byte", {24'd0, mon_byte}, {24'd0, exp_tx.pop_front()});
            end
        end
    end

    // Receive driver: presents next bit on each falling serial edge
    logic       rx_drv_en = 1'b0;
    logic [7:0] rx_pat = '0;
    int         rx_idx = 0;
    always @(negedge sclk_line) begin
        if (rx_drv_en && rx_idx < 8) begin
            rxd = rx_pat[rx_idx];
            rx_idx++;
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b1;
    endtask

    task automatic rd_ctrl(output logic [7:0] v);
        bus_addr = 1'b1;
        #1 v = bus_rdata;
    endtask

    task automatic rd_data(output logic [7:0] v);
        @(negedge clk);
        bus_addr = 1'b0; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 1'b1;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        forever begin
            @(negedge clk);
            rd_ctrl(v);
            if (v[5:4] == 2'b00) break;
        end
    endtask

    task automatic ext_clock(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sclk_i = 1'b0;
            repeat (12) @(negedge clk);
            sclk_i = 1'b1;
            repeat (12) @(negedge clk);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic [2:0] ss, input logic eie);
        wr(1'b0, b);
        exp_tx.push_back(b);
        mon_cnt = 0; mon_en = 1'b1;
        wr(1'b1, {1'b0, eie, 2'b01, 1'b0, ss});
        if (ss == 3'd7) ext_clock(8);
        wait_idle();
        mon_en = 1'b0;
    endtask

    task automatic recv(input logic [7:0] b, input logic [2:0] ss, output logic [7:0] got);
        rx_pat = b; rx_idx = 0; rx_drv_en = 1'b1;
        wr(1'b1, {3'b001, 2'b00, ss});
        if (ss == 3'd7) ext_clock(8);
        wait_idle();
        rx_drv_en = 1'b0;
        rd_data(got);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_ctrl(v);
        check("R1 ctrl reset", v, 8'h07);
        check("R1 pins reset", {sclk_oe, txd, irq, sclk_o}, 4'b0101);

        // R2/R3/R4/R5 internal transmit, fastest ratio
        send(8'hA5, 3'd0, 1'b1);
        check("R2 period ss0", period, 20);
        @(negedge clk); rd_ctrl(v);
        check("R4 end flag and enable clear", v, 8'hC0);
        check("R5 irq on", irq, 1'b1);
        rd_data(v);
        @(negedge clk); rd_ctrl(v);
        check("R7 data read clears flag", v, 8'h40);
        check("R5 irq off", irq, 1'b0);

        // R2 slower ratio
        send(8'h3C, 3'd2, 1'b0);
        check("R2 period ss2", period, 80);

        // R6 internal receive
        recv(8'h96, 3'd1, v);
        check("R6 rx internal", v, 8'h96);
        check("R2 period ss1", period, 40);

        // R9 both enables written
        wr(1'b0, 8'h11);
        exp_tx.push_back(8'h11);
        mon_cnt = 0; mon_en = 1'b1;
        wr(1'b1, 8'h30);
        @(negedge clk); rd_ctrl(v);
        check("R9 only transmit enabled", v, 8'h10);
        wait_idle();
        mon_en = 1'b0;

        // R10/R11 stop-I/O abort
        rd_data(v);
        wr(1'b0, 8'h77);
        wr(1'b1, 8'h10);
        repeat (50) @(negedge clk);
        stop_io = 1'b1;
        @(negedge clk); stop_io = 1'b0;
        rd_ctrl(v);
        check("R10 stop clears enables, no flag", v, 8'h00);
        begin
            int lows = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (sclk_o !== 1'b1) lows++;
            end
            check("R11 clock idle high", lows, 0);
        end

        // R8 external transmit and receive
        send(8'h5A, 3'd7, 1'b0);
        @(negedge clk); rd_ctrl(v);
        check("R8 ext tx end, no drive", {v, 7'd0, sclk_oe}, {8'h87, 8'h00});
        check("R5 irq masked", irq, 1'b0);
        rd_data(v);
        recv(8'hC3, 3'd7, v);
        check("R8 rx external", v, 8'hC3);

        // R12 end of byte and data read in the same cycle
        wr(1'b0, 8'hE1);
        exp_tx.push_back(8'hE1);
        mon_cnt = 0; mon_en = 1'b1;
        wr(1'b1, 8'h57);
        rd_ctrl(v);
        check("R7 enable write clears flag", v, 8'h57);
        ext_clock(7);
        @(negedge clk); sclk_i = 1'b0;
        repeat (12) @(negedge clk);
        sclk_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 1'b1;
        rd_ctrl(v);
        check("R12 set wins over read", v, 8'hC7);
        check("R12 irq held", irq, 1'b1);
        mon_en = 1'b0;
        rd_data(v);
        rd_ctrl(v);
        check("R7 later read clears", v, 8'h47);

        repeat (5) @(negedge clk);
        check("R3 scoreboard drained", exp_tx.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule